// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair

This block is a sequential arithmetic engine that sits beside an integer datapath. It takes a command made of a major opcode, a function code and two source words. It then runs a signed or unsigned multiply, or a signed or unsigned divide, over one iteration per clock. The results go into a dedicated pair of result registers, HI and LO. Commands that read HI or LO return the stored word on a result port. A three-operand multiply variant returns the low product word on the same result port and leaves the pair untouched.

The engine takes one command at a time. While it iterates, `busy_o` is high and `cmd_ready_o` is low. A read presented during that time waits, held by the caller, until the arithmetic finishes. An arithmetic command presented during that time is simply not taken. Signed operands are converted to magnitudes before iterating, and the signs are restored when the iterations end. Division truncates toward zero. A zero divisor gives a fixed, checkable answer.

Top module: `mdu_core`

## Requirements
- R1: After reset, HI and LO hold zero, `busy_o` and `res_valid_o` are low and `cmd_ready_o` is high.
- R2: Commands decode as follows. With major 0x00, function 0x18 is a signed multiply, 0x19 an unsigned multiply, 0x1a a signed divide, 0x1b an unsigned divide, 0x10 a read of HI and 0x12 a read of LO. Major 0x1c with function 0x02 is the three-operand multiply.
- R3: A multiply places the upper half of the 2W-bit product in HI and the lower half in LO. The signed form treats both operands as two's complement; the unsigned form treats them as unsigned.
- R4: A divide places the quotient in LO and the remainder in HI. The signed quotient truncates toward zero, and the remainder takes the dividend's sign. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: A zero divisor, signed or unsigned, leaves LO all ones and HI equal to the raw dividend.
- R6: The three-operand multiply pulses `res_valid_o` for one cycle with the low W bits of the signed product, and it leaves HI and LO unchanged.
- R7: `busy_o` rises on the cycle after an arithmetic command is accepted and stays high for exactly W+1 cycles. `cmd_ready_o` is low throughout, and HI and LO change only on the final cycle.
- R8: An accepted read pulses `res_valid_o` on the next cycle, carrying the current HI or LO. A read held during busy is accepted only after busy drops, so it returns the new result.
- R9: An arithmetic command presented while busy has no effect on the running operation or its results.
- R10: Any other major/function combination is accepted but does not start an operation, does not produce a result, and does not alter HI or LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command taken on this edge when valid |
| cmd_major_i | input | 6 | Major opcode |
| cmd_func_i | input | 6 | Function code |
| rs_i | input | W | First source (multiplicand / dividend) |
| rt_i | input | W | Second source (multiplier / divisor) |
| busy_o | output | 1 | Iteration in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | W | Read data or three-operand product |

## Verification
Multiplies are tried with mixed-sign, both-negative, most-negative-squared, all-ones-unsigned and zero operands. Together these separate sign restoration from magnitude iteration and show the signed and unsigned forms apart on the same bit patterns. Divides cover every sign combination of small values, which separates truncation toward zero from flooring and shows the sign rule for the remainder. The divide cases also include the most negative value over -1, an unsigned dividend smaller than its divisor, and zero divisors of both signedness. Further sequences cover the command that arrives while busy, codes the unit does not recognize, and the three-operand multiply between two reads of the result pair. These show whether state is kept or overwritten.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  localparam logic [5:0] MAJ_REG = 6'h00;
  localparam logic [5:0] MAJ_EXT = 6'h1c;
  localparam logic [5:0] FN_MULS = 6'h18;
  localparam logic [5:0] FN_MULU = 6'h19;
  localparam logic [5:0] FN_DIVS = 6'h1a;
  localparam logic [5:0] FN_DIVU = 6'h1b;
  localparam logic [5:0] FN_RDHI = 6'h10;
  localparam logic [5:0] FN_RDLO = 6'h12;
  localparam logic [5:0] FN_MUL3 = 6'h02;

  typedef enum logic [2:0] {
    K_NONE, K_MULS, K_MULU, K_DIVS, K_DIVU, K_MUL3, K_RDHI, K_RDLO
  } kind_e;
endpackage

// File: rtl/mdu_decode.sv
`timescale 1ns/1ps
module mdu_decode
  import mdu_pkg::*;
(
  input  logic [5:0] major_i,
  input  logic [5:0] func_i,
  output kind_e      kind_o,
  output logic       is_mul_o,
  output logic       is_div_o,
  output logic       signed_o
);
  // R2: command code table
  always_comb begin
    kind_o = K_NONE;
    if (major_i == MAJ_REG) begin
      case (func_i)
        FN_MULS: kind_o = K_MULS;
        FN_MULU: kind_o = K_MULU;
        FN_DIVS: kind_o = K_DIVS;
        FN_DIVU: kind_o = K_DIVU;
        FN_RDHI: kind_o = K_RDHI;
        FN_RDLO: kind_o = K_RDLO;
        default: kind_o = K_NONE;
      endcase
    end else if (major_i == MAJ_EXT && func_i == FN_MUL3) begin
      kind_o = K_MUL3;
    end
  end

  assign is_mul_o = (kind_o == K_MULS) || (kind_o == K_MULU) || (kind_o == K_MUL3);
  assign is_div_o = (kind_o == K_DIVS) || (kind_o == K_DIVU);
  assign signed_o = (kind_o == K_MULS) || (kind_o == K_DIVS) || (kind_o == K_MUL3);
endmodule

// File: rtl/mdu_mul_iter.sv
`timescale 1ns/1ps
module mdu_mul_iter #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  mcand_q, hi_q, lo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    sum;

  // shift-add step: conditionally add, then shift the pair right
  always_comb begin
    sum = lo_q[0] ? ({1'b0, hi_q} + {1'b0, mcand_q}) : {1'b0, hi_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        mcand_q <= mcand_i;
        hi_q    <= '0;
        lo_q    <= mplier_i;
        cnt_q   <= CW'(W);
        run_q   <= 1'b1;
      end else if (run_q) begin
        {hi_q, lo_q} <= {sum, lo_q[W-1:1]};
        cnt_q        <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = {hi_q, lo_q};

  AST_MUL_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_MUL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W)); // R7
endmodule

// File: rtl/mdu_div_iter.sv
`timescale 1ns/1ps
module mdu_div_iter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dsr_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  dsr_q, quo_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;

  // restoring step: bring down one dividend bit, try subtracting
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dsr_q <= dsr_i;
        quo_q <= dvd_i;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[W+1]) begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
    (run_q && dsr_q != '0) |-> (rem_q < dsr_q)); // R4
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
endmodule

// File: rtl/mdu_core.sv
`timescale 1ns/1ps
module mdu_core
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid_i,
  output logic         cmd_ready_o,
  input  logic [5:0]   cmd_major_i,
  input  logic [5:0]   cmd_func_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic         busy_o,
  output logic         res_valid_o,
  output logic [W-1:0] res_data_o
);
  kind_e          kind;
  logic           is_mul, is_div, sgn;
  logic           accept, go;
  logic           neg_a, neg_b;
  logic [W-1:0]   mag_a, mag_b;
  logic           mul_done, div_done;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0]   quo, rem, quo_fix, rem_fix;

  logic           busy_q, neg_q, rneg_q, dz_q, rv_q;
  kind_e          kind_q;
  logic [W-1:0]   dvd_q, hi_q, lo_q, rd_q;

  mdu_decode u_dec (
    .major_i  (cmd_major_i),
    .func_i   (cmd_func_i),
    .kind_o   (kind),
    .is_mul_o (is_mul),
    .is_div_o (is_div),
    .signed_o (sgn)
  );

  assign accept = cmd_valid_i && !busy_q;
  assign go     = accept && (is_mul || is_div);

  // magnitudes for the unsigned iterators
  assign neg_a = sgn && rs_i[W-1];
  assign neg_b = sgn && rt_i[W-1];
  assign mag_a = neg_a ? (~rs_i + 1'b1) : rs_i;
  assign mag_b = neg_b ? (~rt_i + 1'b1) : rt_i;

  mdu_mul_iter #(.W(W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .start_i  (go && is_mul),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .done_o   (mul_done),
    .prod_o   (prod)
  );

  mdu_div_iter #(.W(W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (go && is_div),
    .dvd_i   (mag_a),
    .dsr_i   (mag_b),
    .done_o  (div_done),
    .quo_o   (quo),
    .rem_o   (rem)
  );

  // sign restoration and zero-divisor override
  assign prod_fix = neg_q ? (~prod + 1'b1) : prod;
  assign quo_fix  = dz_q ? '1 : (neg_q ? (~quo + 1'b1) : quo);
  assign rem_fix  = dz_q ? dvd_q : (rneg_q ? (~rem + 1'b1) : rem);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= K_NONE;
      neg_q  <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
      dvd_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      rv_q <= 1'b0;
      if (accept) begin
        case (kind)
          K_RDHI: begin
            rv_q <= 1'b1;
            rd_q <= hi_q;
          end
          K_RDLO: begin
            rv_q <= 1'b1;
            rd_q <= lo_q;
          end
          K_MULS, K_MULU, K_MUL3, K_DIVS, K_DIVU: begin
            busy_q <= 1'b1;
            kind_q <= kind;
            neg_q  <= neg_a ^ neg_b;
            rneg_q <= neg_a;
            dz_q   <= (rt_i == '0);
            dvd_q  <= rs_i;
          end
          default: ;
        endcase
      end else if (busy_q && (mul_done || div_done)) begin
        busy_q <= 1'b0;
        case (kind_q)
          K_MUL3: begin
            rv_q <= 1'b1;
            rd_q <= prod_fix[W-1:0];
          end
          K_MULS, K_MULU: begin
            hi_q <= prod_fix[2*W-1:W];
            lo_q <= prod_fix[W-1:0];
          end
          K_DIVS, K_DIVU: begin
            hi_q <= rem_fix;
            lo_q <= quo_fix;
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign res_valid_o = rv_q;
  assign res_data_o  = rd_q;

  AST_READ_HI_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_RDHI) |=> (rv_q && rd_q == $past(hi_q))); // R8
  AST_HILO_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(mul_done || div_done)) |=> ($stable(hi_q) && $stable(lo_q))); // R7
  AST_BUSY_KIND_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_valid_i) |=> $stable(kind_q)); // R9
  AST_MUL3_KEEPS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (busy_q && kind_q == K_MUL3) |=> ($stable(hi_q) && $stable(lo_q))); // R6
  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_NONE) |=> (!busy_q && !rv_q)); // R10
  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(mul_done || div_done)); // R7
endmodule

// File: tb/mdu_core_test.sv
`timescale 1ns/1ps
module mdu_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [5:0]   major = '0, func = '0;
  logic [W-1:0] rs = '0, rt = '0;
  logic         cmd_ready_o, busy_o, res_valid_o;
  logic [W-1:0] res_data_o;

  always #2.5 clk = ~clk;

  mdu_core #(.W(W)) uut (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready_o),
    .cmd_major_i (major),
    .cmd_func_i  (func),
    .rs_i        (rs),
    .rt_i        (rt),
    .busy_o      (busy_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_e;
  string       mon_t;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: compare every produced result against the scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result strobe", res_data_o, 32'h0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(res_data_o === mon_e, mon_t, res_data_o, mon_e);
      end
    end
  end

  function automatic logic [63:0] ref_mul(input bit s, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // returns {remainder, quotient}
  function automatic logic [63:0] ref_div(input bit s, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 32'h0) return {a, 32'hffff_ffff};
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q  = sa / sb;
      r  = sa % sb;
      return {32'(r), 32'(q)};
    end
    return {a % b, a / b};
  endfunction

  task automatic issue(input logic [5:0] mj, input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; major = mj; func = fn; rs = a; rt = b;
    while (!cmd_ready_o) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] mj, input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; major = mj; func = fn; rs = a; rt = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_reg(input bit hi, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(6'h00, hi ? 6'h10 : 6'h12, 32'h0, 32'h0);
  endtask

  task automatic arith(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [63:0] e;
    case (fn)
      6'h18: e = ref_mul(1'b1, a, b);
      6'h19: e = ref_mul(1'b0, a, b);
      6'h1a: e = ref_div(1'b1, a, b);
      default: e = ref_div(1'b0, a, b);
    endcase
    issue(6'h00, fn, a, b);
    read_reg(1'b1, e[63:32], {tag, " HI"});
    read_reg(1'b0, e[31:0],  {tag, " LO"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", 32'h0, 32'h1);
      report();
      $finish;
    end
  end

  initial begin
    logic [63:0] p;
    int n;
    bit rdy_seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy after reset", {31'b0, busy_o}, 32'h0);
    check(cmd_ready_o == 1'b1, "R1 ready after reset", {31'b0, cmd_ready_o}, 32'h1);
    check(res_valid_o == 1'b0, "R1 no result after reset", {31'b0, res_valid_o}, 32'h0);
    read_reg(1'b1, 32'h0, "R1 HI after reset");
    read_reg(1'b0, 32'h0, "R1 LO after reset");

    // R2 R3 multiplies
    arith(6'h18, 32'd7, 32'hffff_fffd, "R3 R2 muls 7*-3");
    arith(6'h18, 32'h8000_0000, 32'h8000_0000, "R3 muls minneg^2");
    arith(6'h19, 32'hffff_ffff, 32'hffff_ffff, "R3 R2 mulu allones");
    arith(6'h18, 32'h1234_5678, 32'h9abc_def0, "R3 muls mixed");
    arith(6'h19, 32'h1234_5678, 32'h9abc_def0, "R3 mulu mixed");
    arith(6'h18, 32'h0, 32'hffff_fffb, "R3 muls zero");

    // R2 R4 divides
    arith(6'h1a, 32'hffff_fff9, 32'd2, "R4 R2 divs -7/2");
    arith(6'h1a, 32'd7, 32'hffff_fffe, "R4 divs 7/-2");
    arith(6'h1a, 32'hffff_fff9, 32'hffff_fffe, "R4 divs -7/-2");
    arith(6'h1a, 32'h8000_0000, 32'hffff_ffff, "R4 divs minneg/-1");
    arith(6'h1b, 32'hffff_ffff, 32'd10, "R4 R2 divu big/10");
    arith(6'h1b, 32'd5, 32'hffff_ffff, "R4 divu small/big");
    arith(6'h1b, 32'hffff_fff9, 32'd2, "R4 divu pattern");

    // R5 zero divisor
    arith(6'h1a, 32'hffff_fff7, 32'h0, "R5 divs by zero");
    arith(6'h1b, 32'd123, 32'h0, "R5 divu by zero");

    // R6 three-operand multiply keeps the pair
    arith(6'h19, 32'd6, 32'd7, "R6 setup");
    p = ref_mul(1'b1, 32'hffff_fffc, 32'd5);
    exp_q.push_back(p[31:0]);
    tag_q.push_back("R6 R2 mul3 result");
    issue(6'h1c, 6'h02, 32'hffff_fffc, 32'd5);
    read_reg(1'b1, 32'h0, "R6 HI kept");
    read_reg(1'b0, 32'd42, "R6 LO kept");

    // R7 busy window
    issue(6'h00, 6'h1b, 32'd1000, 32'd3);
    n = 0;
    rdy_seen = 0;
    while (busy_o) begin
      n++;
      if (cmd_ready_o) rdy_seen = 1;
      @(negedge clk);
    end
    check(n == W + 1, "R7 busy length", 32'(n), 32'(W + 1));
    check(!rdy_seen, "R7 ready low while busy", {31'b0, rdy_seen}, 32'h0);
    read_reg(1'b0, 32'd333, "R7 LO after window");

    // R9 command while busy is dropped
    issue(6'h00, 6'h18, 32'd3, 32'd4);
    pulse(6'h00, 6'h1a, 32'd100, 32'd7);
    read_reg(1'b1, 32'h0, "R9 HI unaffected");
    read_reg(1'b0, 32'd12, "R9 LO unaffected");

    // R10 unknown codes
    issue(6'h00, 6'h20, 32'd9, 32'd9);
    check(busy_o == 1'b0, "R10 no start funct 0x20", {31'b0, busy_o}, 32'h0);
    issue(6'h1c, 6'h00, 32'd9, 32'd9);
    check(busy_o == 1'b0, "R10 no start ext 0x00", {31'b0, busy_o}, 32'h0);
    repeat (3) @(negedge clk);
    read_reg(1'b1, 32'h0, "R10 HI unchanged");
    read_reg(1'b0, 32'd12, "R10 LO unchanged");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 32'h0);
    if (!finished) begin
      finished = 1;
      report();
      $finish;
    end
  end
endmodule